// File: doc/BRIEF.md
# Processor-Side Bus Arbitration Controller

This block sits inside a bus-master processor and decides when the processor hands its external bus to another master and when it takes the bus back. Another master asks for the bus by pulling an active-low request line. The request is asynchronous to the processor clock, so it first passes through a flop synchronizer. After that, a five-state machine issues an active-low grant and an internal release signal. The release signal tells the processor's control-line drivers to float.

Grant and release do not move together. Both rise together when a request is taken. When the request is withdrawn, the grant falls first. Release stays high for two more cycles, and only then does the processor drive its control lines again. The grant pin is retimed onto the falling clock edge, so it moves half a cycle after the state change that caused it. The bus sequencer raises a read-modify-write flag while an indivisible sequence is running. While that flag is high, no new grant is issued. A request that comes back during the release tail goes straight back to granting, without passing through idle.

Top module: `bus_arb_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, `bus_grant_n` is 1 and `ctl_release` is 0.
- R2: A low level on `bus_req_n` that is set up before rising edge k is acted on at rising edge k+2 (two synchronizer stages, default), and not earlier.
- R3: With no recognised request, the block stays idle: `ctl_release` is 0 and `bus_grant_n` is 1.
- R4: When a request is taken, grant and release assert at the same state change. One cycle later the block enters a hold state, and it keeps both asserted for as long as the recognised request stays low.
- R5: When the recognised request goes high in the hold state, grant negates and release stays 1 for exactly two cycles. Then release returns to 0, so the processor drives its control lines again.
- R6: `bus_grant_n` changes only on falling clock edges. Just after a rising edge it still holds the value it had before that edge.
- R7: While `rmw_active` is 1, a recognised request causes no grant and no release.
- R8: If a request is recognised in either of the two grant-negated, release-asserted states, the next state asserts grant again. Release stays 1 throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_n | input | 1 | Active-low bus request from another master, asynchronous |
| rmw_active | input | 1 | High while the bus sequencer runs a read-modify-write sequence |
| bus_grant_n | output | 1 | Active-low bus grant, updated on the falling clock edge |
| ctl_release | output | 1 | High while the processor must float its bus control lines |

## Verification
A request applied between edges moves `ctl_release` at the third rising edge that follows. `bus_grant_n` follows half a cycle later, on the next falling edge. A withdrawal follows the same pattern, and release then lags grant by two further rising edges.

The bench drives inputs just after a falling edge. It compares `ctl_release` one time unit after each rising edge, against a behavioural model advanced by that same edge. It compares `bus_grant_n` twice per cycle. The first check is just after the rising edge, where the old value must still hold. The second is after the falling edge, where the new value is due.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

  typedef enum logic [2:0] {
    ARB_IDLE  = 3'd0,  // processor owns the bus
    ARB_GRANT = 3'd1,  // grant and release just asserted
    ARB_HOLD  = 3'd2,  // other master owns the bus
    ARB_DROP  = 3'd3,  // grant withdrawn, lines still floating
    ARB_RECOV = 3'd4   // last cycle before the processor drives again
  } arb_state_e;

  function automatic logic grant_of(input arb_state_e s);
    return (s == ARB_GRANT) || (s == ARB_HOLD);
  endfunction

  function automatic logic release_of(input arb_state_e s);
    return s != ARB_IDLE;
  endfunction

  function automatic logic take_request(input logic req, input logic rmw);
    return req && !rmw;
  endfunction

  function automatic arb_state_e next_state(input arb_state_e s,
                                            input logic req,
                                            input logic rmw);
    arb_state_e n;
    unique case (s)
      ARB_IDLE:  n = take_request(req, rmw) ? ARB_GRANT : ARB_IDLE;
      ARB_GRANT: n = ARB_HOLD;
      ARB_HOLD:  n = req ? ARB_HOLD : ARB_DROP;
      ARB_DROP:  n = take_request(req, rmw) ? ARB_GRANT : ARB_RECOV;
      ARB_RECOV: n = take_request(req, rmw) ? ARB_GRANT : ARB_IDLE;
      default:   n = ARB_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bus_arb_sync.sv
module bus_arb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic req_seen
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= async_n;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[LAST-1:0], async_n};
      end
    end
  endgenerate

  assign req_seen = ~chain[LAST];
endmodule

// File: rtl/bus_arb_fsm.sv
module bus_arb_fsm
  import bus_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_seen,
  input  logic rmw_active,
  output logic grant_int,
  output logic release_int,
  output logic in_hold
);
  arb_state_e state_q;
  arb_state_e state_d;

  always_comb state_d = next_state(state_q, req_seen, rmw_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARB_IDLE;
    else        state_q <= state_d;
  end

  assign grant_int   = grant_of(state_q);
  assign release_int = release_of(state_q);
  assign in_hold     = (state_q == ARB_HOLD);
endmodule

// File: rtl/bus_arb_pin.sv
module bus_arb_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_int,
  output logic grant_pin_n
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) grant_pin_n <= 1'b1;
    else        grant_pin_n <= ~grant_int;
  end
endmodule

// File: rtl/bus_arb_ctrl.sv
module bus_arb_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_n,
  input  logic rmw_active,
  output logic bus_grant_n,
  output logic ctl_release
);
  logic req_seen;
  logic grant_int;
  logic release_int;
  logic in_hold;

  bus_arb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_n  (bus_req_n),
    .req_seen (req_seen)
  );

  bus_arb_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_seen    (req_seen),
    .rmw_active  (rmw_active),
    .grant_int   (grant_int),
    .release_int (release_int),
    .in_hold     (in_hold)
  );

  bus_arb_pin pin_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_int   (grant_int),
    .grant_pin_n (bus_grant_n)
  );

  assign ctl_release = release_int;
endmodule

// File: rtl/bus_arb_ctrl_chk.sv
module bus_arb_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_seen,
  input logic rmw_active,
  input logic grant_int,
  input logic in_hold,
  input logic bus_grant_n,
  input logic ctl_release
);
  AST_GRANT_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    grant_int |-> ctl_release); // R4

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_release && !req_seen) |=> !ctl_release); // R3

  AST_RMW_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_release && rmw_active) |=> (!ctl_release && !grant_int)); // R7

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && req_seen) |=> (grant_int && ctl_release)); // R4

  AST_RELEASE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_int) |-> ctl_release); // R5

  AST_RELEASE_TAIL2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_int) |=> ctl_release); // R5

  AST_PIN_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant_n == !grant_int); // R6

  AST_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_release && !grant_int && req_seen && !rmw_active) |=> grant_int); // R8
endmodule

bind bus_arb_ctrl bus_arb_ctrl_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_seen    (req_seen),
  .rmw_active  (rmw_active),
  .grant_int   (grant_int),
  .in_hold     (in_hold),
  .bus_grant_n (bus_grant_n),
  .ctl_release (ctl_release)
);

// File: tb/bus_arb_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_arb_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC_DEPTH = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req_n = 1'b1;
  logic rmw_active = 1'b0;
  logic bus_grant_n;
  logic ctl_release;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model: synchronizer as a queue, phase as integer
  // phase 0 idle, 1 first grant cycle, 2 holding, 3 and 4 release tail
  int sync_q[$];
  int phase = 0;
  logic m_pin_n = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arb_ctrl #(.SYNC_STAGES(SYNC_DEPTH)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req_n   (bus_req_n),
    .rmw_active  (rmw_active),
    .bus_grant_n (bus_grant_n),
    .ctl_release (ctl_release)
  );

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    sync_q.delete();
    for (int i = 0; i < SYNC_DEPTH; i++) sync_q.push_back(1);
    phase = 0;
    m_pin_n = 1'b1;
  endtask

  function automatic bit model_grant();
    return (phase == 1) || (phase == 2);
  endfunction

  // one cycle: inputs applied here, sampled at next rising edge
  task automatic step(input logic req_n, input logic rmw, input string tag);
    int seen_n;
    bus_req_n = req_n;
    rmw_active = rmw;
    @(posedge clk);
    #1;
    check("R6", "grant pin held after rising edge", bus_grant_n, m_pin_n);
    seen_n = sync_q.pop_front();
    sync_q.push_back(int'(req_n));
    if (phase == 0) begin
      if (seen_n == 0 && !rmw) phase = 1;
    end else if (phase == 1) begin
      phase = 2;
    end else if (phase == 2) begin
      if (seen_n != 0) phase = 3;
    end else begin
      if (seen_n == 0 && !rmw) phase = 1;
      else if (phase == 3) phase = 4;
      else phase = 0;
    end
    check(tag, "ctl_release", ctl_release, phase != 0);
    @(negedge clk);
    #1;
    m_pin_n = !model_grant();
    check(tag, "bus_grant_n after falling edge", bus_grant_n, m_pin_n);
  endtask

  task automatic repeat_step(input int n, input logic req_n, input logic rmw,
                             input string tag);
    for (int i = 0; i < n; i++) step(req_n, rmw, tag);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    int lat;
    model_reset();
    #(CLK_PERIOD * 2 + 1);
    check("R1", "grant pin in reset", bus_grant_n, 1'b1);
    check("R1", "release in reset", ctl_release, 1'b0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    check("R1", "grant pin after reset", bus_grant_n, 1'b1);
    check("R1", "release after reset", ctl_release, 1'b0);

    repeat_step(5, 1'b1, 1'b0, "R3");

    // R2: latency of a fresh request, counted in rising edges
    lat = 0;
    for (int i = 0; i < 6 && phase == 0; i++) begin
      step(1'b0, 1'b0, "R2");
      lat++;
    end
    check("R2", "edges to release", 1'(lat == SYNC_DEPTH + 1), 1'b1);
    repeat_step(8, 1'b0, 1'b0, "R4");
    // rmw raised while another master holds the bus: no effect on hold
    repeat_step(3, 1'b0, 1'b1, "R4");
    repeat_step(6, 1'b1, 1'b0, "R5");

    // R7: request during read-modify-write is ignored
    repeat_step(8, 1'b0, 1'b1, "R7");
    check("R7", "no release under rmw", ctl_release, 1'b0);
    repeat_step(5, 1'b0, 1'b0, "R7");
    // R8: one-cycle withdrawal re-requests in the first tail state
    step(1'b1, 1'b0, "R8");
    repeat_step(6, 1'b0, 1'b0, "R8");
    // R8: two-cycle withdrawal re-requests in the second tail state
    repeat_step(2, 1'b1, 1'b0, "R8");
    repeat_step(6, 1'b0, 1'b0, "R8");
    // rmw in the tail blocks the re-grant
    repeat_step(2, 1'b1, 1'b0, "R7");
    repeat_step(4, 1'b0, 1'b1, "R7");
    repeat_step(4, 1'b1, 1'b0, "R5");

    // short pulse from idle runs the full sequence
    step(1'b0, 1'b0, "R4");
    repeat_step(8, 1'b1, 1'b0, "R5");

    // reset while holding
    repeat_step(6, 1'b0, 1'b0, "R4");
    rst_n = 1'b0;
    bus_req_n = 1'b1;
    #1;
    model_reset();
    check("R1", "grant pin on mid-run reset", bus_grant_n, 1'b1);
    check("R1", "release on mid-run reset", ctl_release, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
    repeat_step(4, 1'b1, 1'b0, "R3");
    repeat_step(6, 1'b0, 1'b0, "R4");
    repeat_step(6, 1'b1, 1'b0, "R5");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule